// File: doc/BRIEF.md
# Receive Pad and FCS Stripper

This block is a streaming byte filter placed between the receive side of an Ethernet MAC and the receive FIFO. It looks at each arriving frame byte by byte. After the two address fields it reads the 2-byte length/type word, which arrives most significant byte first. When stripping is switched on and that word is a length below the minimum payload of 46 bytes, the block forwards only the 14 header bytes and the real LLC data bytes. It then drops the pad and the 4-byte frame check sequence. Because the dropped check sequence would no longer match the shortened data, the receiver never stores a check value that cannot be verified.

Frames with a length of 46 or more pass unchanged. So do frames whose word is above 1500, which is read as a type field, and all frames when stripping is off. The end-of-frame marker is moved onto the last byte that is kept. A frame that ends before its declared data is complete is forwarded in full, and an error flag is raised together with its end-of-frame marker. Every byte that is kept comes out exactly one clock after it is accepted.

Top module: `rx_pad_strip`

## Requirements
- R1: With stripping off for a frame, every input byte is forwarded with its data, start and end markers unchanged, and the error flag stays 0.
- R2: The stripping enable is sampled on the start-of-frame byte and applies to the whole frame; a change during the frame has no effect on that frame.
- R3: Byte indices count from 0 at the start-of-frame byte. The length word is made from byte 12 (most significant) and byte 13. With stripping on and length L below 46, bytes 0 to 13+L are forwarded and every later byte of the frame (pad and FCS) is dropped.
- R4: When trailing bytes are dropped, the end-of-frame marker is carried by byte 13+L, the last forwarded byte.
- R5: A length from 46 to 1500 forwards the whole frame unchanged, FCS included.
- R6: A length/type word above 1500 is a type field; the whole frame is forwarded unchanged.
- R7: A length of 0 forwards exactly the 14 header bytes; byte 13 carries end-of-frame.
- R8: With stripping on, a frame that ends before byte 13+L, or before byte 13, is forwarded in full and its last byte has the error flag set. The error flag is never set on any other byte.
- R9: A forwarded byte appears on the output exactly one clock after it is accepted, with start-of-frame on byte 0 only. After reset the output valid is 0.
- R10: Clocks with input valid low neither advance the byte position nor produce output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strip_en | input | 1 | Pad and FCS stripping enable, sampled at start of frame |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is first of frame |
| in_eof | input | 1 | Input byte is last of frame |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte is first of frame |
| out_eof | output | 1 | Output byte is last forwarded byte of frame |
| out_err | output | 1 | Frame ended before its declared data was complete |

## Verification
A wrong byte position or a length word captured from the wrong byte shows up at the ports within one frame. The forwarded byte count changes and end-of-frame lands on the wrong byte, one clock after the byte it should have marked. A stale drop state or enable left over from the previous frame shows up on the next frame as missing bytes or a missing start marker. The tests therefore cover length values on both sides of 46, the value 0, type values, truncated frames, a mid-frame enable change and idle gaps. Each frame's byte count, content and markers are compared with values computed from the requirements.

// File: rtl/rxps_pkg.sv
package rxps_pkg;

    typedef enum logic [1:0] {
        LEN_SHORT = 2'd0,
        LEN_FULL  = 2'd1,
        LEN_TYPE  = 2'd2
    } len_kind_e;

    function automatic len_kind_e classify_len(input logic [15:0] word,
                                               input int unsigned min_pl,
                                               input int unsigned max_len);
        if (32'(word) > max_len)      return LEN_TYPE;
        else if (32'(word) < min_pl)  return LEN_SHORT;
        else                          return LEN_FULL;
    endfunction

endpackage

// File: rtl/rxps_pos_cnt.sv
module rxps_pos_cnt #(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    output logic [CNT_W-1:0] idx
);
    typedef struct packed {
        logic [CNT_W-1:0] pos;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        idx  = in_sof ? '0 : st_q.pos;
        if (in_valid) begin
            if (idx != {CNT_W{1'b1}}) st_d.pos = idx + 1'b1;
            else                      st_d.pos = idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_sof_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_sof |=> st_q.pos == CNT_W'(1));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q.pos));

endmodule

// File: rtl/rxps_len_track.sv
module rxps_len_track
    import rxps_pkg::*;
#(
    parameter int unsigned CNT_W       = 11,
    parameter int unsigned HDR_BYTES   = 14,
    parameter int unsigned MIN_PAYLOAD = 46,
    parameter int unsigned MAX_LEN     = 1500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [7:0]       in_data,
    input  logic [CNT_W-1:0] idx,
    input  logic             en_frame,
    output logic             strip_act,
    output logic [CNT_W-1:0] last_idx
);
    localparam logic [CNT_W-1:0] MSB_POS = CNT_W'(HDR_BYTES - 2);
    localparam logic [CNT_W-1:0] LSB_POS = CNT_W'(HDR_BYTES - 1);

    typedef struct packed {
        logic [7:0]       msb;
        logic             strip;
        logic [CNT_W-1:0] last;
    } len_st_t;

    len_st_t st_d, st_q;

    logic [15:0]      len_word;
    len_kind_e        kind;
    logic             at_len;
    logic             strip_now;
    logic [CNT_W-1:0] last_now;

    always_comb begin
        st_d      = st_q;
        len_word  = {st_q.msb, in_data};
        kind      = classify_len(len_word, MIN_PAYLOAD, MAX_LEN);
        at_len    = in_valid && !in_sof && (idx == LSB_POS);
        strip_now = en_frame && (kind == LEN_SHORT);
        last_now  = LSB_POS + CNT_W'(len_word);

        if (at_len) begin
            strip_act = strip_now;
            last_idx  = last_now;
        end else begin
            strip_act = in_sof ? 1'b0 : st_q.strip;
            last_idx  = st_q.last;
        end

        if (in_valid) begin
            if (in_sof) begin
                st_d.strip = 1'b0;
                st_d.last  = '0;
            end
            if (!in_sof && idx == MSB_POS) st_d.msb = in_data;
            if (at_len) begin
                st_d.strip = strip_now;
                st_d.last  = last_now;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_last_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strip |-> st_q.last < CNT_W'(HDR_BYTES + MIN_PAYLOAD - 1));

    p_sof_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_sof |=> !st_q.strip);

endmodule

// File: rtl/rx_pad_strip.sv
module rx_pad_strip #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned HDR_BYTES   = 14,
    parameter int unsigned MIN_PAYLOAD = 46,
    parameter int unsigned MAX_LEN     = 1500,
    parameter int unsigned CNT_W       = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strip_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_err
);
    localparam logic [CNT_W-1:0] LSB_POS = CNT_W'(HDR_BYTES - 1);

    typedef struct packed {
        logic              en;
        logic              drop;
        logic              vld;
        logic [DATA_W-1:0] data;
        logic              sof;
        logic              eof;
        logic              err;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [CNT_W-1:0] idx;
    logic             strip_act;
    logic [CNT_W-1:0] last_idx;
    logic             en_frame;
    logic             fwd;
    logic             mark;
    logic             early_end;

    assign en_frame = in_sof ? strip_en : st_q.en;

    rxps_pos_cnt #(.CNT_W(CNT_W)) pos_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .idx      (idx)
    );

    rxps_len_track #(
        .CNT_W       (CNT_W),
        .HDR_BYTES   (HDR_BYTES),
        .MIN_PAYLOAD (MIN_PAYLOAD),
        .MAX_LEN     (MAX_LEN)
    ) len_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_data   (in_data[7:0]),
        .idx       (idx),
        .en_frame  (en_frame),
        .strip_act (strip_act),
        .last_idx  (last_idx)
    );

    always_comb begin
        st_d      = st_q;
        fwd       = in_valid && (in_sof || !st_q.drop);
        mark      = in_eof || (strip_act && idx == last_idx);
        early_end = en_frame && ((idx < LSB_POS) || (strip_act && idx < last_idx));

        st_d.vld  = fwd;
        st_d.data = fwd ? in_data : st_q.data;
        st_d.sof  = fwd && in_sof;
        st_d.eof  = fwd && mark;
        st_d.err  = fwd && in_eof && early_end;

        if (in_valid) begin
            st_d.en = en_frame;
            if (in_eof)           st_d.drop = 1'b0;
            else if (fwd && mark) st_d.drop = 1'b1;
            else if (in_sof)      st_d.drop = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign out_sof   = st_q.sof;
    assign out_eof   = st_q.eof;
    assign out_err   = st_q.err;

    p_drop_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.drop && in_valid && !in_sof |=> !out_valid);

    p_off_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !en_frame |=> out_valid && out_data == $past(in_data)
                                  && out_eof == $past(in_eof) && !out_err);

    p_err_on_eof_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_valid && out_eof);

    p_sof_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_sof |=> out_valid && out_sof && out_data == $past(in_data));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

endmodule

// File: tb/rx_pad_strip_tb.sv
module rx_pad_strip_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strip_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_sof;
    logic       out_eof;
    logic       out_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] cap_data [0:4095];
    logic       cap_sof  [0:4095];
    logic       cap_eof  [0:4095];
    logic       cap_err  [0:4095];
    int         cap_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_pad_strip dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strip_en  (strip_en),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sof   (out_sof),
        .out_eof   (out_eof),
        .out_err   (out_err)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid && cap_n < 4096) begin
            cap_data[cap_n] = out_data;
            cap_sof[cap_n]  = out_sof;
            cap_eof[cap_n]  = out_eof;
            cap_err[cap_n]  = out_err;
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input int i, input int lf);
        if (i == 12) return lf[15:8];
        if (i == 13) return lf[7:0];
        return 8'((i * 13 + 5) & 255);
    endfunction

    // lf: length/type word; nbytes: frame size; en0: enable at start byte;
    // en1: enable driven on later bytes; gaps: insert idle cycles
    task automatic send_frame(input int lf, input int nbytes, input bit en0,
                              input bit en1, input bit gaps, input string req);
        int start;
        int keep;
        bit exp_err;
        int mism;
        int sof_bad;
        int eof_bad;
        int err_bad;
        start = cap_n;
        for (int i = 0; i < nbytes; i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_data  = 8'hEE;
                in_sof   = 1'b0;
                in_eof   = 1'b0;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = fbyte(i, lf);
            in_sof   = (i == 0);
            in_eof   = (i == nbytes - 1);
            strip_en = (i == 0) ? en0 : en1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
        repeat (3) @(negedge clk);

        keep = nbytes;
        exp_err = 1'b0;
        if (en0) begin
            if (nbytes < 14) exp_err = 1'b1;
            else if (lf < 46) begin
                if (nbytes < 14 + lf) exp_err = 1'b1;
                else keep = 14 + lf;
            end
        end

        check(cap_n - start == keep, req, "byte count", cap_n - start, keep);
        mism = 0; sof_bad = 0; eof_bad = 0; err_bad = 0;
        for (int k = 0; k < keep && (start + k) < cap_n; k++) begin
            if (cap_data[start + k] !== fbyte(k, lf)) mism++;
            if (cap_sof[start + k] !== (k == 0)) sof_bad++;
            if (cap_eof[start + k] !== (k == keep - 1)) eof_bad++;
            if (cap_err[start + k] !== ((k == keep - 1) && exp_err)) err_bad++;
        end
        check(mism == 0, req, "data mismatches", mism, 0);
        check(sof_bad == 0, "R9", "sof marker errors", sof_bad, 0);
        check(eof_bad == 0, req, "eof marker errors", eof_bad, 0);
        check(err_bad == 0, "R8", "err flag errors", err_bad, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
        check(out_eof == 1'b0 && out_err == 1'b0, "R9", "markers after reset",
              int'({out_eof, out_err}), 0);
    endtask

    task automatic t_passthru_r1;   send_frame(10, 64, 1'b0, 1'b0, 1'b0, "R1"); endtask
    task automatic t_short_r3;      send_frame(5, 64, 1'b1, 1'b1, 1'b0, "R3"); endtask
    task automatic t_boundary_r4;   send_frame(45, 64, 1'b1, 1'b1, 1'b0, "R4"); endtask
    task automatic t_full_r5;       send_frame(46, 64, 1'b1, 1'b1, 1'b0, "R5"); endtask
    task automatic t_long_r5;       send_frame(100, 118, 1'b1, 1'b1, 1'b0, "R5"); endtask
    task automatic t_type_r6;       send_frame(16'h0800, 64, 1'b1, 1'b1, 1'b0, "R6"); endtask
    task automatic t_type_edge_r6;  send_frame(1501, 64, 1'b1, 1'b1, 1'b0, "R6"); endtask
    task automatic t_zero_r7;       send_frame(0, 64, 1'b1, 1'b1, 1'b0, "R7"); endtask
    task automatic t_trunc_r8;      send_frame(20, 25, 1'b1, 1'b1, 1'b0, "R8"); endtask
    task automatic t_hdr_trunc_r8;  send_frame(3, 10, 1'b1, 1'b1, 1'b0, "R8"); endtask
    task automatic t_exact_r4;      send_frame(8, 22, 1'b1, 1'b1, 1'b0, "R4"); endtask
    task automatic t_latch_on_r2;   send_frame(7, 64, 1'b1, 1'b0, 1'b0, "R2"); endtask
    task automatic t_latch_off_r2;  send_frame(7, 64, 1'b0, 1'b1, 1'b0, "R2"); endtask
    task automatic t_gaps_r10;      send_frame(12, 64, 1'b1, 1'b1, 1'b1, "R10"); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_passthru_r1();
        t_short_r3();
        t_boundary_r4();
        t_full_r5();
        t_long_r5();
        t_type_r6();
        t_type_edge_r6();
        t_zero_r7();
        t_trunc_r8();
        t_hdr_trunc_r8();
        t_short_r3();
        t_exact_r4();
        t_latch_on_r2();
        t_latch_off_r2();
        t_gaps_r10();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule